// File: doc/BRIEF.md
# Program Trace Packet Decoder

This block sits on the byte stream that a processor's trace port sends out. It rebuilds the control-flow events that a tag-tracking coprocessor needs. When it comes out of reset it is not locked. It throws away every byte until it sees a synchronization run. Once locked, it splits the stream into packets. Each packet is one of three kinds:

- a start packet, which carries the full address where execution begins;
- a branch packet, which carries a compressed branch target;
- some other packet, which is dropped.

Each start or branch packet produces one event on the output. The event carries a 32-bit address, its kind and a one-cycle valid strobe. A branch packet can be as short as a single byte. The decoder therefore keeps the last address it rebuilt and takes every bit that a branch packet leaves out from that address. A window filter with a parameter-set number of inclusive address ranges can hold back events whose address lies outside the enabled ranges. Address tracking goes on for held-back events as well.

The synchronization run may also turn up in the middle of a locked stream. In that case the decoder locks again and clears its address history. If the run began inside a packet that was not yet complete, it also raises a one-cycle error pulse.

Top module: `trc_decoder`

## Requirements
- R1: While reset is high and after it is released, `locked`, `ev_valid` and `sync_err` are 0.
- R2: While unlocked, every byte is discarded and no event appears. The decoder locks after at least five consecutive accepted 0x00 bytes followed by 0x80. A shorter zero run followed by 0x80 does not lock it.
- R3: When locked, a header byte of 0x08 starts a start packet. The next four accepted bytes give the address, least significant byte first. The cycle after the fourth byte, `ev_valid` pulses with `ev_kind` = 0 and that address with bit 0 forced to 0.
- R4: When locked, a header byte with bit 0 = 1 starts a branch packet. The header's bits [6:1] give address bits [6:1]. Each further byte's bits [6:0] give address bits [13:7], [20:14] and [27:21], in that order. A fifth byte's bits [3:0] give bits [31:28]. Bit 7 of a byte set to 1 means that another byte follows, except in the fifth byte, which always ends the packet. Bits that the packet does not supply come from the last address. Bit 0 is 0. The cycle after the last byte, `ev_valid` pulses with `ev_kind` = 1.
- R5: Every branch packet yields exactly one event, and the last address becomes the address just rebuilt. So N one-byte branch packets in a row yield N events.
- R6: When locked, a header byte with bit 0 = 0 that is not 0x08 is dropped as a one-byte packet. This includes 0x00, and 0x80 when it does not complete a synchronization run. It produces no event and leaves the last address unchanged.
- R7: An event is output only if its address lies within [lo, hi], inclusive, of at least one enabled window. When no window is enabled, every event is output. The last address is updated whether or not the event is output.
- R8: A synchronization run that completes while locked restarts packet parsing at a header byte and sets the last address to 0. It emits no event.
- R9: `sync_err` pulses for exactly one cycle, the cycle after the 0x80 of a synchronization run completes while locked, when the first 0x00 of that run arrived while a start or branch packet was still incomplete.
- R10: Bytes presented with `in_valid` low have no effect on parsing, on events or on the count of consecutive zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` holds a trace byte this cycle |
| in_byte | input | 8 | Trace stream byte |
| win_en | input | NREG | Per-window enable |
| win_lo | input | NREG*32 | Lower bounds, inclusive; window i in bits [32i+31:32i] |
| win_hi | input | NREG*32 | Upper bounds, inclusive; window i in bits [32i+31:32i] |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_addr | output | 32 | Rebuilt address of the event |
| ev_kind | output | 1 | 0 = start address, 1 = branch target |
| sync_err | output | 1 | One-cycle pulse: a synchronization run cut a packet short |
| locked | output | 1 | A synchronization run has been seen since reset |

## Verification
The stream is driven with the following patterns, and each one separates a different failure:

- **Junk and a four-zero run before lock.** This separates a decoder that parses too early, or locks on too short a run, from a correct one.
- **Back-to-back one-byte branch packets.** A ten-packet loop shows whether bits left out of a packet come from the previous target and whether each packet yields exactly one event.
- **Branch packets of two to five bytes.** These include a fifth byte with bit 7 set, which shows whether each byte fills the correct address field and whether the packet stops at five bytes.
- **Dropped header bytes between branches.** These show that a dropped byte leaves the address history alone.
- **Gaps with `in_valid` low, inside packets and inside zero runs.**
- **Window settings.** With no window enabled, one window, the other window and both, the pattern separates the range check from the address tracking that goes on for held-back events.
- **Mid-stream synchronization runs.** These start while idle, inside a start packet and inside a branch packet. They show whether the error pulse depends on where the run began.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int ADDR_W        = 32;
    localparam int SYNC_ZEROS    = 5;
    localparam logic [7:0] SYNC_TAIL = 8'h80;
    localparam logic [7:0] HDR_START = 8'h08;
    localparam int START_BYTES   = 4;
    localparam int BR_MAX_BYTES  = 5;
    localparam int CNT_W         = $clog2(BR_MAX_BYTES);
    localparam int ZRUN_W        = $clog2(SYNC_ZEROS + 1);

    typedef enum logic [1:0] {
        PS_HUNT,
        PS_HDR,
        PS_START,
        PS_BRANCH
    } pstate_t;

    typedef enum logic {
        EV_START  = 1'b0,
        EV_BRANCH = 1'b1
    } ev_kind_t;

    typedef struct packed {
        logic              valid;
        ev_kind_t          kind;
        logic [ADDR_W-1:0] addr;
    } trc_event_t;

    // Fold one branch-packet byte into the address it refines.
    function automatic logic [ADDR_W-1:0] merge_branch(
        input logic [ADDR_W-1:0] prev,
        input logic [7:0]        b,
        input logic [CNT_W-1:0]  idx
    );
        logic [ADDR_W-1:0] r;
        r = prev;
        case (idx)
            3'd0: begin
                r[6:1] = b[6:1];
                r[0]   = 1'b0;
            end
            3'd1: r[13:7]  = b[6:0];
            3'd2: r[20:14] = b[6:0];
            3'd3: r[27:21] = b[6:0];
            3'd4: r[31:28] = b[3:0];
            default: r = prev;
        endcase
        return r;
    endfunction

    // Drop one start-packet payload byte into its lane, low byte first.
    function automatic logic [ADDR_W-1:0] place_byte(
        input logic [ADDR_W-1:0] acc,
        input logic [7:0]        b,
        input logic [CNT_W-1:0]  idx
    );
        logic [ADDR_W-1:0] r;
        r = acc;
        case (idx)
            3'd0: r[7:0]   = b;
            3'd1: r[15:8]  = b;
            3'd2: r[23:16] = b;
            3'd3: r[31:24] = b;
            default: r = acc;
        endcase
        return r;
    endfunction

    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] lo,
        input logic [ADDR_W-1:0] hi
    );
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/trc_sync_hunt.sv
module trc_sync_hunt
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       parser_busy,
    output logic       sync_hit,
    output logic       locked,
    output logic       sync_err
);

    localparam logic [ZRUN_W-1:0] ZRUN_FULL = ZRUN_W'(SYNC_ZEROS);

    logic [ZRUN_W-1:0] zrun;
    logic              run_mid;

    assign sync_hit = in_valid && (in_byte == SYNC_TAIL) && (zrun == ZRUN_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun     <= '0;
            run_mid  <= 1'b0;
            locked   <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            sync_err <= sync_hit && locked && run_mid;
            if (sync_hit) begin
                locked <= 1'b1;
            end
            if (in_valid) begin
                if (in_byte == 8'h00) begin
                    if (zrun == '0) begin
                        run_mid <= parser_busy;
                    end
                    if (zrun != ZRUN_FULL) begin
                        zrun <= zrun + 1'b1;
                    end
                end else begin
                    zrun <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/trc_pkt_parser.sv
module trc_pkt_parser
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       sync_hit,
    output logic       busy,
    output trc_event_t raw_ev
);

    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_BYTES - 1);
    localparam logic [CNT_W-1:0] BR_LAST    = CNT_W'(BR_MAX_BYTES - 1);

    pstate_t           st;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] acc;
    logic [CNT_W-1:0]  cnt;

    logic [ADDR_W-1:0] br_next;
    logic [ADDR_W-1:0] start_next;
    logic              br_more;

    always_comb begin
        if (st == PS_HDR) begin
            br_next = merge_branch(last_addr, in_byte, '0);
        end else begin
            br_next = merge_branch(acc, in_byte, cnt);
        end
        start_next = place_byte(acc, in_byte, cnt);
        br_more    = in_byte[7] && (cnt != BR_LAST);
    end

    assign busy = (st == PS_START) || (st == PS_BRANCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_HUNT;
            last_addr <= '0;
            acc       <= '0;
            cnt       <= '0;
            raw_ev    <= '0;
        end else begin
            raw_ev.valid <= 1'b0;
            if (sync_hit) begin
                st        <= PS_HDR;
                last_addr <= '0;
                cnt       <= '0;
            end else if (in_valid) begin
                unique case (st)
                    PS_HUNT: begin
                        st <= PS_HUNT;
                    end
                    PS_HDR: begin
                        if (in_byte[0]) begin
                            if (in_byte[7]) begin
                                acc <= br_next;
                                cnt <= CNT_W'(1);
                                st  <= PS_BRANCH;
                            end else begin
                                raw_ev.valid <= 1'b1;
                                raw_ev.kind  <= EV_BRANCH;
                                raw_ev.addr  <= br_next;
                                last_addr    <= br_next;
                            end
                        end else if (in_byte == HDR_START) begin
                            acc <= '0;
                            cnt <= '0;
                            st  <= PS_START;
                        end
                    end
                    PS_START: begin
                        acc <= start_next;
                        if (cnt == START_LAST) begin
                            raw_ev.valid <= 1'b1;
                            raw_ev.kind  <= EV_START;
                            raw_ev.addr  <= {start_next[ADDR_W-1:1], 1'b0};
                            last_addr    <= {start_next[ADDR_W-1:1], 1'b0};
                            st           <= PS_HDR;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PS_BRANCH: begin
                        if (br_more) begin
                            acc <= br_next;
                            cnt <= cnt + 1'b1;
                        end else begin
                            raw_ev.valid <= 1'b1;
                            raw_ev.kind  <= EV_BRANCH;
                            raw_ev.addr  <= br_next;
                            last_addr    <= br_next;
                            st           <= PS_HDR;
                        end
                    end
                    default: st <= PS_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/trc_window_filter.sv
module trc_window_filter
    import trc_pkg::*;
#(
    parameter int NREG = 2
) (
    input  trc_event_t               raw_ev,
    input  logic [NREG-1:0]          win_en,
    input  logic [NREG*ADDR_W-1:0]   win_lo,
    input  logic [NREG*ADDR_W-1:0]   win_hi,
    output trc_event_t               qual_ev
);

    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_win
        assign hit[i] = win_en[i] &&
                        in_window(raw_ev.addr,
                                  win_lo[i*ADDR_W +: ADDR_W],
                                  win_hi[i*ADDR_W +: ADDR_W]);
    end

    logic pass;
    assign pass = (win_en == '0) || (|hit);

    always_comb begin
        qual_ev       = raw_ev;
        qual_ev.valid = raw_ev.valid && pass;
    end

endmodule

// File: rtl/trc_decoder.sv
module trc_decoder
    import trc_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    input  logic [NREG-1:0]        win_en,
    input  logic [NREG*32-1:0]     win_lo,
    input  logic [NREG*32-1:0]     win_hi,
    output logic                   ev_valid,
    output logic [31:0]            ev_addr,
    output logic                   ev_kind,
    output logic                   sync_err,
    output logic                   locked
);

    logic       sync_hit;
    logic       parser_busy;
    trc_event_t raw_ev;
    trc_event_t qual_ev;

    trc_sync_hunt u_hunt (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .parser_busy (parser_busy),
        .sync_hit    (sync_hit),
        .locked      (locked),
        .sync_err    (sync_err)
    );

    trc_pkt_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .sync_hit (sync_hit),
        .busy     (parser_busy),
        .raw_ev   (raw_ev)
    );

    trc_window_filter #(.NREG(NREG)) u_filter (
        .raw_ev  (raw_ev),
        .win_en  (win_en),
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .qual_ev (qual_ev)
    );

    assign ev_valid = qual_ev.valid;
    assign ev_addr  = qual_ev.addr;
    assign ev_kind  = qual_ev.kind;

endmodule

// File: rtl/trc_decoder_chk.sv
module trc_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  in_byte,
    input logic        ev_valid,
    input logic [31:0] ev_addr,
    input logic        sync_err,
    input logic        locked
);

    // R2: lock is gained only on the tail byte of a sync run
    a_r2_lock_on_tail: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid && in_byte == 8'h80));

    // R2: no event leaves an unlocked decoder
    a_r2_no_event_unlocked: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> locked);

    // R8: once locked, lock is kept until reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R10: an event always follows an accepted byte
    a_r10_event_needs_byte: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(in_valid));

    // R3 / R4: rebuilt addresses are halfword aligned
    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_addr[0] == 1'b0));

    // R9: the error is a single-cycle pulse
    a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    // R9: the error follows a sync tail byte while locked
    a_r9_err_on_tail: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> ($past(in_valid && in_byte == 8'h80) && locked));

endmodule

bind trc_decoder trc_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .ev_valid (ev_valid),
    .ev_addr  (ev_addr),
    .sync_err (sync_err),
    .locked   (locked)
);

// File: tb/trc_decoder_bench.sv
`timescale 1ns/1ps
module trc_decoder_bench;

    localparam int NREG = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [7:0]        in_byte;
    logic [NREG-1:0]   win_en;
    logic [NREG*32-1:0] win_lo;
    logic [NREG*32-1:0] win_hi;
    logic              ev_valid;
    logic [31:0]       ev_addr;
    logic              ev_kind;
    logic              sync_err;
    logic              locked;

    always #10 clk = ~clk;

    trc_decoder #(.NREG(NREG)) u_trc_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_kind(ev_kind),
        .sync_err(sync_err), .locked(locked)
    );

    int tests = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    bit          m_locked = 0;
    int          m_zeros = 0;
    bit          m_runmid = 0;
    int          m_st = 0;      // 0 header, 1 start payload, 2 branch tail
    int          m_cnt = 0;
    logic [31:0] m_acc = 0;
    logic [31:0] m_last = 0;
    bit          x_v;
    logic [31:0] x_a;
    bit          x_k;
    bit          x_err;
    int          ev_seen = 0;
    int          err_seen = 0;

    function automatic bit model_pass(input logic [31:0] a);
        bit any = 0;
        if (win_en == 0) return 1;
        for (int i = 0; i < NREG; i++) begin
            if (win_en[i] && a >= win_lo[i*32 +: 32] && a <= win_hi[i*32 +: 32]) any = 1;
        end
        return any;
    endfunction

    function automatic void model_emit(input bit k, input logic [31:0] a);
        m_last = a;
        if (model_pass(a)) begin
            x_v = 1; x_a = a; x_k = k;
        end
    endfunction

    function automatic void model_step(input bit v, input logic [7:0] b);
        int pos[5] = '{1, 7, 14, 21, 28};
        int wid[5] = '{6, 7, 7, 7, 4};
        logic [31:0] mask;
        logic [31:0] field;
        x_v = 0; x_err = 0;
        if (!v) return;
        if (b == 8'h80 && m_zeros >= 5) begin
            x_err = m_locked && m_runmid;
            m_locked = 1; m_st = 0; m_last = 0; m_zeros = 0;
            return;
        end
        if (b == 8'h00) begin
            if (m_zeros == 0) m_runmid = m_locked && (m_st != 0);
            m_zeros++;
        end else begin
            m_zeros = 0;
        end
        if (!m_locked) return;
        case (m_st)
            0: begin
                if (b[0]) begin
                    m_acc = (m_last & ~32'h7F) | {24'h0, b & 8'h7E};
                    if (b[7]) begin m_st = 2; m_cnt = 1; end
                    else model_emit(1, m_acc);
                end else if (b == 8'h08) begin
                    m_st = 1; m_cnt = 0; m_acc = 0;
                end
            end
            1: begin
                m_acc = m_acc | (32'(b) << (8 * m_cnt));
                m_cnt++;
                if (m_cnt == 4) begin
                    m_st = 0;
                    model_emit(0, m_acc & ~32'h1);
                end
            end
            default: begin
                mask  = (32'h1 << wid[m_cnt]) - 1;
                field = 32'(b) & mask;
                m_acc = (m_acc & ~(mask << pos[m_cnt])) | (field << pos[m_cnt]);
                m_cnt++;
                if (!b[7] || m_cnt == 5) begin
                    m_st = 0;
                    model_emit(1, m_acc);
                end
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_byte  = b;
        model_step(v, b);
        @(posedge clk);
        #5;
        if (ev_valid) ev_seen++;
        if (sync_err) err_seen++;
        check(ev_valid == x_v && sync_err == x_err && locked == m_locked,
              "valid/err/locked", {29'd0, ev_valid, sync_err, locked}, {29'd0, x_v, x_err, m_locked});
        if (x_v && ev_valid)
            check(ev_addr == x_a && ev_kind == x_k, "addr/kind",
                  {ev_addr[31:1], ev_kind}, {x_a[31:1], x_k});
    endtask

    task automatic send(input logic [7:0] b); step(1, b); endtask
    task automatic gap(); step(0, 8'h01); endtask
    task automatic sync_run();
        for (int i = 0; i < 5; i++) send(8'h00);
        send(8'h80);
    endtask
    task automatic set_win(input int i, input bit en, input logic [31:0] lo, input logic [31:0] hi);
        win_en[i] = en;
        win_lo[i*32 +: 32] = lo;
        win_hi[i*32 +: 32] = hi;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired in %s", tag);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_byte = 0;
        win_en = '0; win_lo = '0; win_hi = '0;
        repeat (3) @(posedge clk);
        #5;
        tag = "R1";
        check(locked == 0 && ev_valid == 0 && sync_err == 0, "reset outputs",
              {29'd0, ev_valid, sync_err, locked}, 32'd0);
        @(negedge clk);
        rst = 0;
        @(posedge clk); #5;
        check(locked == 0 && ev_valid == 0 && sync_err == 0, "after reset",
              {29'd0, ev_valid, sync_err, locked}, 32'd0);

        // R2: junk and a short zero run do not lock
        tag = "R2";
        send(8'h08); send(8'h12); send(8'h01); send(8'h2B);
        for (int i = 0; i < 4; i++) send(8'h00);
        send(8'h80);
        check(locked == 0, "short run locked", {31'd0, locked}, 32'd0);
        // R10: idle cycles inside the zero run do not break it
        tag = "R10";
        send(8'h00); send(8'h00); gap(); send(8'h00); gap(); gap();
        send(8'h00); send(8'h00);
        send(8'h80);
        check(locked == 1, "lock across idle gaps", {31'd0, locked}, 32'd1);

        // R3: start packet, bit 0 forced low
        tag = "R3";
        send(8'h08); send(8'h35); send(8'h12); gap(); send(8'h00); send(8'h80);
        check(x_a == 32'h80001234, "start address model", x_a, 32'h80001234);

        // R5: ten one-byte branch packets
        tag = "R5";
        ev_seen = 0;
        for (int i = 0; i < 10; i++) send(8'h2B);
        check(ev_seen == 10, "loop event count", ev_seen, 10);

        // R4: multi-byte branches, fifth byte ends packet even with bit 7 set
        tag = "R4";
        send(8'h83); send(8'h05);
        send(8'hFF); send(8'hAA); send(8'h81); send(8'hC2); send(8'hF7);
        send(8'h85); gap(); send(8'h80); send(8'h11);
        send(8'h01);

        // R6: dropped headers leave the last address alone
        tag = "R6";
        send(8'h04); send(8'h00); send(8'h80); send(8'h42); send(8'h06);
        send(8'h7F);

        // R10: invalid cycles inside a branch packet
        tag = "R10";
        send(8'h81); gap(); gap(); send(8'h22);

        // R7: window filtering
        tag = "R7";
        send(8'h08); send(8'h00); send(8'h10); send(8'h00); send(8'h00);
        set_win(0, 1, 32'h0000_1000, 32'h0000_10FF);
        send(8'h21);
        send(8'h81); send(8'h40);
        send(8'h21);
        set_win(0, 0, 32'h0000_1000, 32'h0000_10FF);
        set_win(1, 1, 32'h0000_2000, 32'h0000_20FF);
        send(8'h21);
        send(8'hFF);
        set_win(0, 1, 32'h0000_1000, 32'h0000_10FF);
        send(8'h81); send(8'h20);
        send(8'h01);
        set_win(0, 0, 0, 0); set_win(1, 0, 0, 0);
        send(8'h0D);

        // R8: sync while idle clears last address, no error
        tag = "R8";
        err_seen = 0;
        send(8'h08); send(8'h44); send(8'h33); send(8'h22); send(8'h11);
        sync_run();
        send(8'h03);
        check(err_seen == 0, "error on idle sync", err_seen, 0);

        // R9: sync run starting inside a start packet
        tag = "R9";
        err_seen = 0;
        send(8'h08); send(8'h11); send(8'h00); send(8'h00); send(8'h00);
        send(8'h00); send(8'h00); send(8'h80);
        check(err_seen == 1, "error after cut start", err_seen, 1);
        send(8'h09);
        // R9: sync run starting inside a branch packet
        err_seen = 0;
        send(8'h81);
        sync_run();
        gap();
        check(err_seen == 1, "error after cut branch", err_seen, 1);
        send(8'h2B);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule